// File: doc/BRIEF.md
# Protected Address Translation Buffer

This block is a small fully associative translation buffer that sits between a load/store or fetch unit and the cache. A 32-bit virtual address is split into a 20-bit page number and a 12-bit displacement. The page number is compared against every occupied slot at once. On a match, the physical address is the stored frame number with the unchanged displacement appended below it. Each slot also holds access rights, a resident bit, a dirty bit and a referenced bit. Every lookup is checked against the rights of the matching slot, so a protection fault is reported alongside the translation result.

A lookup is presented for one cycle with its access kind: read, write or execute. One cycle later the response carries exactly one of four outcomes. These are a hit with the translated address, a miss for an outside walker to service, a page fault when the page is not resident, and a protection fault. A permitted hit sets the slot's referenced bit, and a permitted write also sets its dirty bit. The response reports both bits as they stand after the access. A separate fill port installs one slot per cycle. A flush input empties the whole buffer in one cycle.

Top module: `tlb_prot`

## Requirements
- R1: When `req_valid_i` is high, the response appears on the next clock edge with `rsp_valid_o` high. On a hit, `rsp_paddr_o` equals the slot's frame number concatenated with `req_vaddr_i[11:0]`.
- R2: Lookup is fully associative. A page installed in any slot index, from 0 to ENTRIES-1, is found, and at most one slot ever matches a page number.
- R3: When no occupied slot holds the page number, the response is a miss with `rsp_paddr_o`, `rsp_dirty_o` and `rsp_refd_o` all zero.
- R4: When the matching slot was filled with `fill_present_i` low, the response is a page fault and the slot's flags are left unchanged.
- R5: Rights codes are 0 read-only (read allowed), 1 read/write (read and write allowed), 2 execute-only (execute allowed) and 3 no access. Access codes are 0 read, 1 write, 2 execute and 3 never allowed. An access that is not allowed gives a protection fault and leaves the flags unchanged.
- R6: Each response with `rsp_valid_o` high has exactly one of hit, miss, page fault and protection fault set. With `rsp_valid_o` low, all four are low.
- R7: A permitted hit sets the slot's referenced bit, and `rsp_refd_o` shows it as 1 on that response.
- R8: A permitted write hit sets the slot's dirty bit, and `rsp_dirty_o` shows 1. A faulting write leaves the dirty bit as it was.
- R9: A fill whose page number is already held by an occupied slot overwrites that slot, whatever `fill_way_i` says. A fill loads dirty from `fill_dirty_i` and clears referenced.
- R10: A fill of a page number not held anywhere writes the slot selected by `fill_way_i`, and that slot's previous page is lost.
- R11: `flush_i` empties every slot in one cycle, so later lookups miss. A fill in the same cycle is dropped, and a lookup in that cycle still sees the old contents.
- R12: While `rst_ni` is low, all slots are empty and every response output is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| flush_i | input | 1 | Empty all slots |
| req_valid_i | input | 1 | Lookup request |
| req_vaddr_i | input | 32 | Virtual address |
| req_acc_i | input | 2 | Access kind: 0 read, 1 write, 2 execute |
| fill_en_i | input | 1 | Install a slot |
| fill_vpn_i | input | 20 | Page number to install |
| fill_pfn_i | input | 20 | Frame number to install |
| fill_perm_i | input | 2 | Rights code |
| fill_present_i | input | 1 | Page resident |
| fill_dirty_i | input | 1 | Initial dirty bit |
| fill_way_i | input | 4 | Slot used when the page is new |
| rsp_valid_o | output | 1 | Response present |
| rsp_paddr_o | output | 32 | Physical address on hit, else 0 |
| rsp_hit_o | output | 1 | Permitted hit |
| rsp_miss_o | output | 1 | No slot holds the page |
| rsp_page_fault_o | output | 1 | Page not resident |
| rsp_prot_fault_o | output | 1 | Access not allowed |
| rsp_dirty_o | output | 1 | Slot dirty bit after the access |
| rsp_refd_o | output | 1 | Slot referenced bit after the access |

## Verification
Directed lookups cover each rights code against each access kind. This separates correct permission decoding from a decoder that allows too much or too little. A prior faulting write followed by a read shows whether faults wrongly set flags. Pages are installed in every slot index with reversed index order, which exposes any slot whose compare or select is broken. Refills of an existing page into a different way, flush with a coincident fill, and a long run of back-to-back mixed lookups are then compared cycle by cycle with a behavioural model. These distinguish overwrite from duplication, flush priority, and correct ordering of flag updates between consecutive accesses to the same slot.

// File: rtl/tlb_pkg.sv
package tlb_pkg;
  typedef enum logic [1:0] {
    ACC_READ  = 2'd0,
    ACC_WRITE = 2'd1,
    ACC_EXEC  = 2'd2,
    ACC_RSVD  = 2'd3
  } acc_e;

  typedef enum logic [1:0] {
    PERM_RO   = 2'd0,
    PERM_RW   = 2'd1,
    PERM_XO   = 2'd2,
    PERM_NONE = 2'd3
  } perm_e;

  function automatic logic access_ok(perm_e p, acc_e a);
    logic ok;
    unique case (p)
      PERM_RO:  ok = (a == ACC_READ);
      PERM_RW:  ok = (a == ACC_READ) || (a == ACC_WRITE);
      PERM_XO:  ok = (a == ACC_EXEC);
      default:  ok = 1'b0;
    endcase
    return ok;
  endfunction
endpackage

// File: rtl/tlb_match.sv
module tlb_match #(
  parameter int ENTRIES = 16,
  parameter int VPN_W   = 20
) (
  input  logic [VPN_W-1:0]              vpn_i,
  input  logic [ENTRIES-1:0][VPN_W-1:0] tags_i,
  input  logic [ENTRIES-1:0]            used_i,
  output logic [ENTRIES-1:0]            hit_o
);
  for (genvar g = 0; g < ENTRIES; g++) begin : g_cmp
    assign hit_o[g] = used_i[g] && (tags_i[g] == vpn_i);
  end
endmodule

// File: rtl/tlb_enc.sv
module tlb_enc #(
  parameter int ENTRIES = 16,
  parameter int IDX_W   = $clog2(ENTRIES)
) (
  input  logic [ENTRIES-1:0] vec_i,
  output logic [IDX_W-1:0]   idx_o,
  output logic               any_o
);
  // OR of indices: exact when vec_i is one-hot
  always_comb begin
    idx_o = '0;
    for (int i = 0; i < ENTRIES; i++) begin
      if (vec_i[i]) idx_o = idx_o | IDX_W'(i);
    end
  end
  assign any_o = |vec_i;
endmodule

// File: rtl/tlb_store.sv
module tlb_store #(
  parameter int ENTRIES = 16,
  parameter int VPN_W   = 20,
  parameter int PFN_W   = 20,
  parameter int IDX_W   = $clog2(ENTRIES)
) (
  input  logic                          clk_i,
  input  logic                          rst_ni,
  input  logic                          flush_i,
  input  logic                          fill_en_i,
  input  logic [IDX_W-1:0]              fill_idx_i,
  input  logic [VPN_W-1:0]              fill_vpn_i,
  input  logic [PFN_W-1:0]              fill_pfn_i,
  input  logic [1:0]                    fill_perm_i,
  input  logic                          fill_present_i,
  input  logic                          fill_dirty_i,
  input  logic                          upd_en_i,
  input  logic [IDX_W-1:0]              upd_idx_i,
  input  logic                          upd_dirty_i,
  output logic [ENTRIES-1:0]            used_o,
  output logic [ENTRIES-1:0]            present_o,
  output logic [ENTRIES-1:0]            dirty_o,
  output logic [ENTRIES-1:0]            refd_o,
  output logic [ENTRIES-1:0][1:0]       perm_o,
  output logic [ENTRIES-1:0][VPN_W-1:0] vpn_o,
  output logic [ENTRIES-1:0][PFN_W-1:0] pfn_o
);
  for (genvar g = 0; g < ENTRIES; g++) begin : g_ent
    logic             used_q, present_q, dirty_q, refd_q;
    logic [1:0]       perm_q;
    logic [VPN_W-1:0] vpn_q;
    logic [PFN_W-1:0] pfn_q;

    // priority: flush, fill, flag update
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        used_q    <= 1'b0;
        present_q <= 1'b0;
        dirty_q   <= 1'b0;
        refd_q    <= 1'b0;
        perm_q    <= '0;
        vpn_q     <= '0;
        pfn_q     <= '0;
      end else if (flush_i) begin
        used_q    <= 1'b0;
        present_q <= 1'b0;
      end else if (fill_en_i && fill_idx_i == IDX_W'(g)) begin
        used_q    <= 1'b1;
        present_q <= fill_present_i;
        dirty_q   <= fill_dirty_i;
        refd_q    <= 1'b0;
        perm_q    <= fill_perm_i;
        vpn_q     <= fill_vpn_i;
        pfn_q     <= fill_pfn_i;
      end else if (upd_en_i && upd_idx_i == IDX_W'(g)) begin
        refd_q <= 1'b1;
        if (upd_dirty_i) dirty_q <= 1'b1;
      end
    end

    assign used_o[g]    = used_q;
    assign present_o[g] = present_q;
    assign dirty_o[g]   = dirty_q;
    assign refd_o[g]    = refd_q;
    assign perm_o[g]    = perm_q;
    assign vpn_o[g]     = vpn_q;
    assign pfn_o[g]     = pfn_q;
  end

  a_r11_flush_empties: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flush_i |=> (used_o == '0));
endmodule

// File: rtl/tlb_prot.sv
module tlb_prot #(
  parameter int ENTRIES = 16,
  parameter int VA_W    = 32,
  parameter int PA_W    = 32,
  parameter int OFF_W   = 12,
  localparam int VPN_W  = VA_W - OFF_W,
  localparam int PFN_W  = PA_W - OFF_W,
  localparam int IDX_W  = $clog2(ENTRIES)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             flush_i,
  input  logic             req_valid_i,
  input  logic [VA_W-1:0]  req_vaddr_i,
  input  logic [1:0]       req_acc_i,
  input  logic             fill_en_i,
  input  logic [VPN_W-1:0] fill_vpn_i,
  input  logic [PFN_W-1:0] fill_pfn_i,
  input  logic [1:0]       fill_perm_i,
  input  logic             fill_present_i,
  input  logic             fill_dirty_i,
  input  logic [IDX_W-1:0] fill_way_i,
  output logic             rsp_valid_o,
  output logic [PA_W-1:0]  rsp_paddr_o,
  output logic             rsp_hit_o,
  output logic             rsp_miss_o,
  output logic             rsp_page_fault_o,
  output logic             rsp_prot_fault_o,
  output logic             rsp_dirty_o,
  output logic             rsp_refd_o
);
  import tlb_pkg::*;

  logic [ENTRIES-1:0]            used, present, dirty, refd;
  logic [ENTRIES-1:0][1:0]       perm;
  logic [ENTRIES-1:0][VPN_W-1:0] tags;
  logic [ENTRIES-1:0][PFN_W-1:0] pfns;

  logic [VPN_W-1:0]   lk_vpn;
  logic [OFF_W-1:0]   lk_off;
  logic [ENTRIES-1:0] lk_vec, fl_vec;
  logic [IDX_W-1:0]   lk_idx, fl_idx, fill_idx;
  logic               lk_any, fl_any;

  assign lk_vpn = req_vaddr_i[VA_W-1:OFF_W];
  assign lk_off = req_vaddr_i[OFF_W-1:0];

  tlb_match #(.ENTRIES(ENTRIES), .VPN_W(VPN_W)) i_lk_match (
    .vpn_i(lk_vpn), .tags_i(tags), .used_i(used), .hit_o(lk_vec));
  tlb_enc #(.ENTRIES(ENTRIES), .IDX_W(IDX_W)) i_lk_enc (
    .vec_i(lk_vec), .idx_o(lk_idx), .any_o(lk_any));

  tlb_match #(.ENTRIES(ENTRIES), .VPN_W(VPN_W)) i_fl_match (
    .vpn_i(fill_vpn_i), .tags_i(tags), .used_i(used), .hit_o(fl_vec));
  tlb_enc #(.ENTRIES(ENTRIES), .IDX_W(IDX_W)) i_fl_enc (
    .vec_i(fl_vec), .idx_o(fl_idx), .any_o(fl_any));

  // existing page is overwritten in place, else the chosen way
  assign fill_idx = fl_any ? fl_idx : fill_way_i;

  logic sel_present, sel_dirty, sel_refd, sel_ok, is_write, found;
  logic [PFN_W-1:0] sel_pfn;
  logic hit_d, miss_d, pf_d, prot_d;

  assign sel_present = present[lk_idx];
  assign sel_dirty   = dirty[lk_idx];
  assign sel_refd    = refd[lk_idx];
  assign sel_pfn     = pfns[lk_idx];
  assign sel_ok      = access_ok(perm_e'(perm[lk_idx]), acc_e'(req_acc_i));
  assign is_write    = (acc_e'(req_acc_i) == ACC_WRITE);
  assign found       = req_valid_i && lk_any;

  always_comb begin
    miss_d = req_valid_i && !lk_any;
    pf_d   = found && !sel_present;
    prot_d = found && sel_present && !sel_ok;
    hit_d  = found && sel_present && sel_ok;
  end

  tlb_store #(.ENTRIES(ENTRIES), .VPN_W(VPN_W), .PFN_W(PFN_W), .IDX_W(IDX_W)) i_store (
    .clk_i(clk_i), .rst_ni(rst_ni), .flush_i(flush_i),
    .fill_en_i(fill_en_i), .fill_idx_i(fill_idx), .fill_vpn_i(fill_vpn_i),
    .fill_pfn_i(fill_pfn_i), .fill_perm_i(fill_perm_i),
    .fill_present_i(fill_present_i), .fill_dirty_i(fill_dirty_i),
    .upd_en_i(hit_d), .upd_idx_i(lk_idx), .upd_dirty_i(is_write),
    .used_o(used), .present_o(present), .dirty_o(dirty), .refd_o(refd),
    .perm_o(perm), .vpn_o(tags), .pfn_o(pfns));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rsp_valid_o      <= 1'b0;
      rsp_paddr_o      <= '0;
      rsp_hit_o        <= 1'b0;
      rsp_miss_o       <= 1'b0;
      rsp_page_fault_o <= 1'b0;
      rsp_prot_fault_o <= 1'b0;
      rsp_dirty_o      <= 1'b0;
      rsp_refd_o       <= 1'b0;
    end else begin
      rsp_valid_o      <= req_valid_i;
      rsp_paddr_o      <= hit_d ? {sel_pfn, lk_off} : '0;
      rsp_hit_o        <= hit_d;
      rsp_miss_o       <= miss_d;
      rsp_page_fault_o <= pf_d;
      rsp_prot_fault_o <= prot_d;
      rsp_dirty_o      <= found && (sel_dirty || (hit_d && is_write));
      rsp_refd_o       <= found && (sel_refd || hit_d);
    end
  end

  a_r2_single_match: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(lk_vec));
  a_r1_rsp_follows_req: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_o == $past(req_valid_i));
  a_r1_offset_kept: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_hit_o |-> rsp_paddr_o[OFF_W-1:0] == $past(req_vaddr_i[OFF_W-1:0]));
  a_r6_one_outcome: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_o |-> $onehot({rsp_hit_o, rsp_miss_o, rsp_page_fault_o, rsp_prot_fault_o}));
  a_r6_idle_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rsp_valid_o |-> !(rsp_hit_o || rsp_miss_o || rsp_page_fault_o || rsp_prot_fault_o));
  a_r3_miss_clean: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_miss_o |-> (rsp_paddr_o == '0 && !rsp_dirty_o && !rsp_refd_o));
  a_r7_hit_refd: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_hit_o |-> rsp_refd_o);
  a_r8_write_dirty: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rsp_hit_o && $past(req_acc_i) == 2'd1) |-> rsp_dirty_o);
endmodule

// File: tb/test_tlb_prot.sv
module test_tlb_prot;
  localparam int N = 16;
  localparam int K_HIT = 0, K_MISS = 1, K_PF = 2, K_PROT = 3;

  logic clk = 1'b0, rst_ni = 1'b0;
  always #5 clk = ~clk;

  logic        flush = 0, req_valid = 0, fill_en = 0, fill_present = 0, fill_dirty = 0;
  logic [31:0] req_vaddr = 0;
  logic [1:0]  req_acc = 0, fill_perm = 0;
  logic [19:0] fill_vpn = 0, fill_pfn = 0;
  logic [3:0]  fill_way = 0;
  logic        rsp_valid, rsp_hit, rsp_miss, rsp_pf, rsp_prot, rsp_dirty, rsp_refd;
  logic [31:0] rsp_paddr;

  tlb_prot i_tlb_prot (
    .clk_i(clk), .rst_ni(rst_ni), .flush_i(flush),
    .req_valid_i(req_valid), .req_vaddr_i(req_vaddr), .req_acc_i(req_acc),
    .fill_en_i(fill_en), .fill_vpn_i(fill_vpn), .fill_pfn_i(fill_pfn),
    .fill_perm_i(fill_perm), .fill_present_i(fill_present), .fill_dirty_i(fill_dirty),
    .fill_way_i(fill_way),
    .rsp_valid_o(rsp_valid), .rsp_paddr_o(rsp_paddr), .rsp_hit_o(rsp_hit),
    .rsp_miss_o(rsp_miss), .rsp_page_fault_o(rsp_pf), .rsp_prot_fault_o(rsp_prot),
    .rsp_dirty_o(rsp_dirty), .rsp_refd_o(rsp_refd));

  int total = 0, bad = 0;
  bit finished = 0;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  // behavioural reference
  typedef struct {
    bit used; bit present; bit dirty; bit refd;
    int perm; int vpn; logic [19:0] pfn;
  } slot_t;
  slot_t mdl[N];
  logic e_v = 0, e_hit = 0, e_miss = 0, e_pf = 0, e_prot = 0, e_d = 0, e_r = 0;
  logic [31:0] e_pa = 0;

  function automatic bit allowed(int p, int a);
    return (p == 0 && a == 0) || (p == 1 && (a == 0 || a == 1)) || (p == 2 && a == 2);
  endfunction

  always @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < N; i++) mdl[i] = '{0, 0, 0, 0, 0, 0, 20'd0};
      {e_v, e_hit, e_miss, e_pf, e_prot, e_d, e_r} = '0;
      e_pa = 0;
    end else begin
      int f, w;
      f = -1;
      {e_hit, e_miss, e_pf, e_prot, e_d, e_r} = '0;
      e_pa = 0;
      e_v = req_valid;
      if (req_valid) begin
        for (int i = 0; i < N; i++)
          if (mdl[i].used && mdl[i].vpn == int'(req_vaddr[31:12])) f = i;
        if (f < 0) e_miss = 1;
        else begin
          e_d = mdl[f].dirty;
          e_r = mdl[f].refd;
          if (!mdl[f].present) e_pf = 1;
          else if (!allowed(mdl[f].perm, int'(req_acc))) e_prot = 1;
          else begin
            e_hit = 1;
            e_pa = {mdl[f].pfn, req_vaddr[11:0]};
            e_r = 1;
            if (req_acc == 2'd1) e_d = 1;
            if (!flush) begin
              mdl[f].refd = 1;
              if (req_acc == 2'd1) mdl[f].dirty = 1;
            end
          end
        end
      end
      if (flush) begin
        for (int i = 0; i < N; i++) begin mdl[i].used = 0; mdl[i].present = 0; end
      end else if (fill_en) begin
        w = int'(fill_way);
        for (int i = 0; i < N; i++)
          if (mdl[i].used && mdl[i].vpn == int'(fill_vpn)) w = i;
        mdl[w] = '{1, fill_present, fill_dirty, 0, int'(fill_perm), int'(fill_vpn), fill_pfn};
      end
    end
  end

  always @(negedge clk) if (!finished) begin
    chk("R1 rsp_valid", 32'(rsp_valid), 32'(e_v));
    chk("R1 rsp_paddr", rsp_paddr, e_pa);
    chk("R2 rsp_hit", 32'(rsp_hit), 32'(e_hit));
    chk("R3 rsp_miss", 32'(rsp_miss), 32'(e_miss));
    chk("R4 rsp_page_fault", 32'(rsp_pf), 32'(e_pf));
    chk("R5 rsp_prot_fault", 32'(rsp_prot), 32'(e_prot));
    chk("R8 rsp_dirty", 32'(rsp_dirty), 32'(e_d));
    chk("R7 rsp_refd", 32'(rsp_refd), 32'(e_r));
  end

  task automatic fill(input logic [19:0] vpn, input logic [19:0] pfn, input logic [1:0] perm,
                      input logic pres, input logic dty, input logic [3:0] way);
    @(negedge clk); #1;
    fill_en = 1; fill_vpn = vpn; fill_pfn = pfn; fill_perm = perm;
    fill_present = pres; fill_dirty = dty; fill_way = way;
    @(posedge clk); #2 fill_en = 0;
  endtask

  // independent directed check of outcome, address and flags
  task automatic look(input logic [31:0] va, input logic [1:0] acc, input int kind,
                      input logic [31:0] pa, input logic d, input logic r, input string tag);
    logic [3:0] want;
    @(negedge clk); #1;
    req_valid = 1; req_vaddr = va; req_acc = acc;
    @(posedge clk); #2 req_valid = 0;
    want = 4'b1000 >> kind;
    chk({tag, " outcome"}, 32'({rsp_hit, rsp_miss, rsp_pf, rsp_prot}), 32'(want));
    chk({tag, " paddr"}, rsp_paddr, (kind == K_HIT) ? pa : 32'd0);
    chk({tag, " dirty"}, 32'(rsp_dirty), 32'(d));
    chk({tag, " refd"}, 32'(rsp_refd), 32'(r));
  endtask

  task automatic finish_run();
    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  initial begin
    #2000000;
    total++; bad++;
    $display("FAIL watchdog expired act=running exp=done");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    // R12: reset state
    chk("R12 outputs in reset",
        32'({rsp_valid, rsp_hit, rsp_miss, rsp_pf, rsp_prot, rsp_dirty, rsp_refd}), 32'd0);
    chk("R12 paddr in reset", rsp_paddr, 32'd0);
    #1 rst_ni = 1;

    look(32'h12345678, 2'd0, K_MISS, 0, 0, 0, "R3 empty lookup");
    fill(20'h12345, 20'hABCDE, 2'd1, 1, 0, 4'd2);
    look(32'h12345678, 2'd0, K_HIT, 32'hABCDE678, 0, 1, "R1 R7 read hit");
    look(32'h12345FFC, 2'd1, K_HIT, 32'hABCDEFFC, 1, 1, "R8 write hit");

    fill(20'h00001, 20'h00111, 2'd0, 1, 0, 4'd15);
    look(32'h00001004, 2'd1, K_PROT, 0, 0, 0, "R5 write to read-only");
    look(32'h00001008, 2'd2, K_PROT, 0, 0, 0, "R5 exec of read-only");
    look(32'h0000100C, 2'd0, K_HIT, 32'h0011100C, 0, 1, "R8 faulted write left clean");

    fill(20'h00002, 20'h00222, 2'd2, 1, 0, 4'd7);
    look(32'h00002010, 2'd2, K_HIT, 32'h00222010, 0, 1, "R5 exec on execute-only");
    look(32'h00002014, 2'd0, K_PROT, 0, 0, 1, "R5 read of execute-only");
    fill(20'h00003, 20'h00333, 2'd3, 1, 0, 4'd8);
    look(32'h00003000, 2'd0, K_PROT, 0, 0, 0, "R5 no-access rights");
    look(32'h12345000, 2'd3, K_PROT, 0, 1, 1, "R5 reserved access code");

    fill(20'h00004, 20'h00444, 2'd1, 0, 0, 4'd9);
    look(32'h00004020, 2'd0, K_PF, 0, 0, 0, "R4 non-resident page");
    look(32'h00004024, 2'd1, K_PF, 0, 0, 0, "R4 flags untouched");

    // R9: refill of a held page overwrites in place
    fill(20'h00005, 20'h00055, 2'd1, 1, 0, 4'd0);
    fill(20'h00005, 20'h00066, 2'd1, 1, 0, 4'd1);
    look(32'h00005000, 2'd0, K_HIT, 32'h00066000, 0, 1, "R9 refill new frame");
    fill(20'h00006, 20'h00077, 2'd1, 1, 0, 4'd0);
    look(32'h00005000, 2'd0, K_MISS, 0, 0, 0, "R9 no duplicate slot");
    look(32'h00006ABC, 2'd0, K_HIT, 32'h00077ABC, 0, 1, "R9 way 0 holds new page");
    fill(20'h00006, 20'h00078, 2'd1, 1, 1, 4'd5);
    look(32'h00006ABC, 2'd0, K_HIT, 32'h00078ABC, 1, 1, "R9 fill loads dirty clears refd");

    // R10: new page replaces the selected way
    fill(20'h00007, 20'h00700, 2'd1, 1, 0, 4'd3);
    fill(20'h00008, 20'h00800, 2'd1, 1, 0, 4'd3);
    look(32'h00007000, 2'd0, K_MISS, 0, 0, 0, "R10 victim evicted");
    look(32'h00008000, 2'd0, K_HIT, 32'h00800000, 0, 1, "R10 new page in way");

    // R2: every slot index
    for (int i = 0; i < N; i++)
      fill(20'h00200 + 20'(i), 20'h00300 + 20'(i), 2'd1, 1, 0, 4'(N - 1 - i));
    for (int i = 0; i < N; i++)
      look({20'h00200 + 20'(i), 12'h0A0}, 2'd0, K_HIT, {20'h00300 + 20'(i), 12'h0A0}, 0, 1,
           "R2 slot lookup");

    // back-to-back mixed traffic, checked against the model (R6)
    for (int c = 0; c < 80; c++) begin
      @(negedge clk); #1;
      req_valid = ($urandom % 4) != 0;
      req_vaddr = {20'h00200 + 20'($urandom % 20), 12'($urandom)};
      req_acc = 2'($urandom % 4);
    end
    @(negedge clk); #1 req_valid = 0;

    // R11: flush beats a same-cycle fill
    @(negedge clk); #1;
    flush = 1; fill_en = 1; fill_vpn = 20'h00400; fill_pfn = 20'h00401;
    fill_perm = 2'd1; fill_present = 1; fill_dirty = 0; fill_way = 4'd0;
    req_valid = 1; req_vaddr = 32'h00205000; req_acc = 2'd0;
    @(posedge clk); #2 flush = 0; fill_en = 0; req_valid = 0;
    chk("R11 lookup during flush sees old contents", 32'(rsp_hit), 32'd1);
    look(32'h00400000, 2'd0, K_MISS, 0, 0, 0, "R11 dropped fill");
    look(32'h00205000, 2'd0, K_MISS, 0, 0, 0, "R11 flushed page");
    look(32'h12345000, 2'd0, K_MISS, 0, 0, 0, "R11 flushed older page");

    repeat (2) @(negedge clk);
    finish_run();
  end
endmodule